// File: doc/BRIEF.md
# Flash toggle-bit status poller

This block sits on the host side of a parallel NOR flash device. It watches the device while a program or erase operation runs. A single-cycle start pulse launches a poll at one address. The block then reads the status byte over a read-request/read-acknowledge handshake, as many times as needed, and compares consecutive reads. When the toggling bit stops changing, the block reports completion. If the device raises its time-limit bit while still toggling, the block makes one confirming pair of reads and then reports either completion or an error. A second mode asks whether the addressed sector is in erase suspend, by comparing the suspend-toggle bit across two reads.

For a program operation, the caller gives the address being programmed. For a sector erase, the caller gives any address inside a sector that is marked for erasure. The caller can set an upper bound on the number of read pairs, so that a missing or stuck device cannot keep the block busy forever.

Top module: `flash_toggle_poller`

## Requirements
- R1: After reset, busy, done, error, susp_flag and rd_req are all 0.
- R2: A start pulse while idle sets busy from the next cycle. It issues reads (rd_req high) at the poll_addr value captured with that start. rd_addr stays constant for the whole poll. No read is requested while idle, and each cycle with rd_ack high while rd_req is high consumes exactly one read and its rd_data.
- R3: Bit 6 is the toggle bit. A poll runs in read pairs. If bit 6 is equal in the two reads of a pair, the poll ends with done and no error.
- R4: Bit 5 is the time-limit bit. If bit 6 differs within a pair and bit 5 of the second read is 0, the block starts another pair of reads.
- R5: If bit 6 differs and bit 5 of the second read is 1, the block makes exactly one more pair of reads. If bit 6 is equal in that pair, it signals done. Otherwise it signals error.
- R6: iter_max is sampled at start. When it is non-zero, a poll that has completed iter_max pairs and would loop again per R4 ends with error instead. When it is 0, there is no limit. The confirming pair of R5 does not count toward the limit.
- R7: With susp_query high at start, the block makes two reads and signals done. susp_flag becomes 1 if bit 2 differs between those reads and 0 if it does not. susp_flag changes only in the cycle where done fires, and keeps its value through later program or erase polls.
- R8: done and error are single-cycle pulses and never fire together. busy is 0 in the cycle where either one fires, and was 1 in the cycle before.
- R9: A start pulse while busy is ignored. The running poll keeps its address, mode and outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a poll (taken only when idle) |
| susp_query | input | 1 | 1 = erase-suspend query, 0 = program/erase completion poll |
| poll_addr | input | AW | Address to read status from |
| iter_max | input | IW | Maximum read pairs, 0 = unlimited |
| rd_req | output | 1 | Read request to the flash bus |
| rd_addr | output | AW | Read address, held for the whole poll |
| rd_ack | input | 1 | Read data valid this cycle |
| rd_data | input | 8 | Status byte from the device |
| busy | output | 1 | Poll in progress |
| done | output | 1 | One-cycle pulse: poll finished without error |
| error | output | 1 | One-cycle pulse: time limit or pair limit exceeded |
| susp_flag | output | 1 | Sector-in-erase-suspend result of the last query |

## Verification
The assertions check the following on every cycle:
- the pulse shape of done and error, and that the two never fire together;
- busy dropping exactly when a pulse fires;
- requests appearing only while busy;
- the read address holding still during a poll;
- susp_flag changing only alongside done.

Only the bench's scenarios can show that the right outcome follows from a given sequence of status bytes. The bench sweeps the stop point of the toggling, the read in which the time-limit bit rises, the pair limit and the acknowledge latency. For each case it checks:
- done versus error;
- the exact number of reads consumed;
- the suspend result.

// File: rtl/ftp_pkg.sv
package ftp_pkg;
   localparam int STAT_W  = 8;
   localparam int BIT_TGL = 6;   // toggles while an operation runs
   localparam int BIT_TMO = 5;   // set when the device time limit is exceeded
   localparam int BIT_SUS = 2;   // toggles on reads of a suspended sector

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RDA  = 2'd1,
      ST_RDB  = 2'd2,
      ST_EVAL = 2'd3
   } ftp_state_t;

   typedef logic [STAT_W-1:0] stat_t;
endpackage

// File: rtl/ftp_rd_port.sv
module ftp_rd_port #(
   parameter int AW = 20
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 launch,
   input  logic [AW-1:0]        addr_in,
   input  logic                 cap_a,
   input  logic                 cap_b,
   input  ftp_pkg::stat_t       data_in,
   output logic [AW-1:0]        addr_q,
   output ftp_pkg::stat_t       byte_a,
   output ftp_pkg::stat_t       byte_b
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         byte_a <= '0;
         byte_b <= '0;
      end else begin
         if (launch) addr_q <= addr_in;
         if (cap_a)  byte_a <= data_in;
         if (cap_b)  byte_b <= data_in;
      end
   end
endmodule

// File: rtl/ftp_iter_cnt.sv
module ftp_iter_cnt #(
   parameter int IW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          inc,
   input  logic [IW-1:0] limit_in,
   output logic          hit
);
   logic [IW-1:0] cnt_q;
   logic [IW-1:0] lim_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         lim_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
         lim_q <= limit_in;
      end else if (inc) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // cnt_q holds the loop-backs taken so far; the pair under evaluation is cnt_q+1
   assign hit = (lim_q != '0) && (cnt_q == lim_q - 1'b1);
endmodule

// File: rtl/ftp_ctrl.sv
module ftp_ctrl #(
   parameter bit SUSPEND_EN = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic           susp_query,
   input  logic           rd_ack,
   input  ftp_pkg::stat_t byte_a,
   input  ftp_pkg::stat_t byte_b,
   input  logic           limit_hit,
   output logic           launch,
   output logic           rd_req,
   output logic           cap_a,
   output logic           cap_b,
   output logic           cnt_inc,
   output logic           done_set,
   output logic           err_set,
   output logic           susp_upd,
   output logic           susp_val,
   output logic           busy
);
   import ftp_pkg::*;

   ftp_state_t st_q, st_d;
   logic       recheck_q, recheck_d;
   logic       mode_q;
   logic       query_mode;
   logic       tgl_diff;

   generate
      if (SUSPEND_EN) begin : g_susp_mode
         always_ff @(posedge clk) begin
            if (!rst_n)      mode_q <= 1'b0;
            else if (launch) mode_q <= susp_query;
         end
         assign query_mode = mode_q;
      end else begin : g_no_susp_mode
         assign mode_q     = 1'b0;
         assign query_mode = 1'b0;
      end
   endgenerate

   assign launch   = start && (st_q == ST_IDLE);
   assign busy     = (st_q != ST_IDLE);
   assign rd_req   = (st_q == ST_RDA) || (st_q == ST_RDB);
   assign cap_a    = (st_q == ST_RDA) && rd_ack;
   assign cap_b    = (st_q == ST_RDB) && rd_ack;
   assign tgl_diff = byte_a[BIT_TGL] ^ byte_b[BIT_TGL];
   assign susp_val = byte_a[BIT_SUS] ^ byte_b[BIT_SUS];

   always_comb begin
      st_d      = st_q;
      recheck_d = recheck_q;
      cnt_inc   = 1'b0;
      done_set  = 1'b0;
      err_set   = 1'b0;
      susp_upd  = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (launch) begin
               st_d      = ST_RDA;
               recheck_d = 1'b0;
            end
         end
         ST_RDA: if (rd_ack) st_d = ST_RDB;
         ST_RDB: if (rd_ack) st_d = ST_EVAL;
         ST_EVAL: begin
            st_d = ST_IDLE;
            if (query_mode) begin
               susp_upd = 1'b1;
               done_set = 1'b1;
            end else if (!tgl_diff) begin
               done_set = 1'b1;
            end else if (recheck_q) begin
               err_set = 1'b1;
            end else if (byte_b[BIT_TMO]) begin
               recheck_d = 1'b1;
               st_d      = ST_RDA;
            end else if (limit_hit) begin
               err_set = 1'b1;
            end else begin
               cnt_inc = 1'b1;
               st_d    = ST_RDA;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         recheck_q <= 1'b0;
      end else begin
         st_q      <= st_d;
         recheck_q <= recheck_d;
      end
   end
endmodule

// File: rtl/flash_toggle_poller.sv
module flash_toggle_poller #(
   parameter int AW         = 20,
   parameter int IW         = 8,
   parameter bit SUSPEND_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          susp_query,
   input  logic [AW-1:0] poll_addr,
   input  logic [IW-1:0] iter_max,
   output logic          rd_req,
   output logic [AW-1:0] rd_addr,
   input  logic          rd_ack,
   input  logic [7:0]    rd_data,
   output logic          busy,
   output logic          done,
   output logic          error,
   output logic          susp_flag
);
   import ftp_pkg::*;

   generate
      if (AW < 1) begin : g_bad_aw
         $error("flash_toggle_poller: AW must be at least 1");
      end
      if (IW < 1 || IW > 32) begin : g_bad_iw
         $error("flash_toggle_poller: IW must be within 1..32");
      end
   endgenerate

   logic  launch, cap_a, cap_b, cnt_inc, limit_hit;
   logic  done_set, err_set, susp_upd, susp_val;
   stat_t byte_a, byte_b;
   logic  done_q, err_q;

   ftp_rd_port #(.AW(AW)) u_port (
      .clk     (clk),
      .rst_n   (rst_n),
      .launch  (launch),
      .addr_in (poll_addr),
      .cap_a   (cap_a),
      .cap_b   (cap_b),
      .data_in (rd_data),
      .addr_q  (rd_addr),
      .byte_a  (byte_a),
      .byte_b  (byte_b)
   );

   ftp_iter_cnt #(.IW(IW)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (launch),
      .inc      (cnt_inc),
      .limit_in (iter_max),
      .hit      (limit_hit)
   );

   ftp_ctrl #(.SUSPEND_EN(SUSPEND_EN)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .susp_query (susp_query),
      .rd_ack     (rd_ack),
      .byte_a     (byte_a),
      .byte_b     (byte_b),
      .limit_hit  (limit_hit),
      .launch     (launch),
      .rd_req     (rd_req),
      .cap_a      (cap_a),
      .cap_b      (cap_b),
      .cnt_inc    (cnt_inc),
      .done_set   (done_set),
      .err_set    (err_set),
      .susp_upd   (susp_upd),
      .susp_val   (susp_val),
      .busy       (busy)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         done_q <= done_set;
         err_q  <= err_set;
      end
   end

   generate
      if (SUSPEND_EN) begin : g_susp_flag
         logic flag_q;
         always_ff @(posedge clk) begin
            if (!rst_n)        flag_q <= 1'b0;
            else if (susp_upd) flag_q <= susp_val;
         end
         assign susp_flag = flag_q;
      end else begin : g_susp_off
         assign susp_flag = 1'b0;
      end
   endgenerate

   assign done  = done_q;
   assign error = err_q;
endmodule

// File: rtl/ftp_checker.sv
module ftp_checker #(
   parameter int AW = 20
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          busy,
   input logic          done,
   input logic          error,
   input logic          rd_req,
   input logic [AW-1:0] rd_addr,
   input logic          susp_flag
);
   AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(done && error)); // R8
   AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
   AST_ERR_ONE: assert property (@(posedge clk) disable iff (!rst_n) error |=> !error); // R8
   AST_IDLE_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n) (done || error) |-> !busy); // R8
   AST_PULSE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (done || error) |-> $past(busy)); // R8
   AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n) rd_req |-> busy); // R2
   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n) (busy && $past(busy)) |-> $stable(rd_addr)); // R2
   AST_START_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy); // R2
   AST_SUSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(susp_flag)); // R7
endmodule

bind flash_toggle_poller ftp_checker #(.AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .busy      (busy),
   .done      (done),
   .error     (error),
   .rd_req    (rd_req),
   .rd_addr   (rd_addr),
   .susp_flag (susp_flag)
);

// File: tb/flash_toggle_poller_test.sv
module flash_toggle_poller_test;
   localparam int AW = 12;
   localparam int IW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          susp_query = 1'b0;
   logic [AW-1:0] poll_addr = '0;
   logic [IW-1:0] iter_max = '0;
   logic          rd_req;
   logic [AW-1:0] rd_addr;
   logic          rd_ack = 1'b0;
   logic [7:0]    rd_data = 8'h00;
   logic          busy, done, error, susp_flag;

   flash_toggle_poller #(.AW(AW), .IW(IW), .SUSPEND_EN(1'b1)) uut (.*);

   always #2 clk = ~clk;   // 250 MHz

   int n_chk = 0;
   int n_bad = 0;
   bit summary_done = 0;

   // device model configuration
   int cfg_t = 0, cfg_f = 0, cfg_lat = 0, cfg_susp_tgl = 0;
   bit cfg_query = 0;
   int run_base = 0;
   int ack_total = 0;
   int addr_bad = 0;
   int wait_cnt = 0;
   logic [AW-1:0] exp_addr = '0;

   function automatic logic [7:0] dev_byte(input int r);
      logic [7:0] b;
      int m;
      b = 8'(r * 37 + 11);
      if (cfg_query) begin
         b[2] = (cfg_susp_tgl != 0) ? r[0] : 1'b1;
         b[6] = r[0];
         b[5] = 1'b1;
      end else begin
         m = (r < cfg_t) ? r : cfg_t;
         b[6] = m[0];
         b[5] = (r >= cfg_f);
      end
      return b;
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // responder: acknowledges each request after cfg_lat waiting cycles
   always @(negedge clk) begin
      if (rd_req && wait_cnt >= cfg_lat) begin
         rd_ack  = 1'b1;
         rd_data = dev_byte(ack_total - run_base);
         if (rd_addr != exp_addr) addr_bad = addr_bad + 1;
         ack_total = ack_total + 1;
         wait_cnt = 0;
      end else begin
         rd_ack = 1'b0;
         if (rd_req) wait_cnt = wait_cnt + 1;
         else        wait_cnt = 0;
      end
   end

   // reference outcome computed from the requirements: kind 1 = done, 2 = error
   task automatic ref_run(input int mi, output int kind, output int nr, output string tag);
      logic [7:0] a, b, c, d;
      int r, pairs;
      r = 0; pairs = 0; kind = 0; tag = "R3";
      if (cfg_query) begin
         kind = 1; nr = 2; tag = "R7";
         return;
      end
      while (kind == 0 && r < 200) begin
         a = dev_byte(r); b = dev_byte(r + 1); r += 2; pairs++;
         if (a[6] == b[6]) kind = 1;
         else if (b[5]) begin
            c = dev_byte(r); d = dev_byte(r + 1); r += 2;
            kind = (c[6] == d[6]) ? 1 : 2;
            tag = "R5";
         end else if (mi != 0 && pairs == mi) begin
            kind = 2; tag = "R6";
         end else tag = "R4";
      end
      nr = r;
   endtask

   bit exp_susp = 0;

   task automatic run_one(input int mi, input logic [AW-1:0] addr, input bit poke);
      int kind, nr, cyc, got, addr_bad0;
      string tag;
      ref_run(mi, kind, nr, tag);
      run_base  = ack_total;
      addr_bad0 = addr_bad;
      exp_addr  = addr;
      poll_addr = addr;
      susp_query = cfg_query;
      iter_max  = IW'(mi);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy === 1'b1 && rd_req === 1'b1 && rd_addr === addr, "R2", int'(busy), 1);
      if (poke) begin
         // R9: second start while busy with other address and mode
         poll_addr  = ~addr;
         susp_query = ~cfg_query;
         iter_max   = IW'(1);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      cyc = 0;
      while (!(done || error) && cyc < 600) begin
         @(negedge clk);
         cyc++;
      end
      if (cyc >= 600) begin
         chk(1'b0, "watchdog", cyc, 600);
         return;
      end
      got = done ? 1 : 2;
      chk(got == kind, tag, got, kind);
      chk(ack_total - run_base == nr, poke ? "R9" : tag, ack_total - run_base, nr);
      chk(busy === 1'b0, "R8", int'(busy), 0);
      chk(addr_bad == addr_bad0, poke ? "R9" : "R2", addr_bad - addr_bad0, 0);
      if (cfg_query) exp_susp = (cfg_susp_tgl != 0);
      chk(susp_flag === exp_susp, "R7", int'(susp_flag), int'(exp_susp));
      @(negedge clk);
      chk(done === 1'b0 && error === 1'b0 && rd_req === 1'b0, "R8", int'(done | error), 0);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!summary_done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
         summary_done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : main
      int mis[3];
      int idx;
      mis[0] = 0; mis[1] = 1; mis[2] = 3;
      repeat (3) @(negedge clk);
      chk(busy === 1'b0 && done === 1'b0 && error === 1'b0 && susp_flag === 1'b0 && rd_req === 1'b0,
          "R1", int'({busy, done, error, susp_flag, rd_req}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy === 1'b0 && rd_req === 1'b0, "R1", int'({busy, rd_req}), 0);
      idx = 0;
      for (int lat = 0; lat < 3; lat++) begin
         cfg_lat = lat;
         // R7 suspend queries, interleaved so the flag must hold across polls
         for (int s = 0; s < 4; s++) begin
            cfg_query = 1'b1;
            cfg_susp_tgl = s % 2;
            run_one(0, AW'(idx * 7 + 1), lat == 2);
            idx++;
            cfg_query = 1'b0;
            cfg_t = s; cfg_f = 9;
            run_one(0, AW'(idx * 7 + 3), 1'b0);
            idx++;
         end
         for (int t = 0; t < 8; t++)
            for (int f = 0; f < 10; f++)
               for (int k = 0; k < 3; k++) begin
                  cfg_query = 1'b0;
                  cfg_t = t; cfg_f = f;
                  run_one(mis[k], AW'(idx * 13 + 5), lat == 2 && f == 3);
                  idx++;
               end
      end
      if (!summary_done) begin
         summary_done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule